// File: doc/BRIEF.md
# Byte/Word Switchable ROM Read Port

This block is a clocked read port onto one read-only array of 16-bit words. It serves that array in one of two ways, chosen by a mode input. In word mode, a 17-bit address picks a word and all sixteen data lanes carry it. In byte mode, a shared pin becomes the least significant address bit and picks one half of the addressed word, which is placed on the low eight lanes. The upper eight lanes then stay floating. In word mode the same shared pin works as the output of data bit 15, and its input side is ignored. The array contents are not stored: a function fills them from the address and a SEED parameter, so the default build needs no memory.

Access timing is counted in clock cycles. Three age counters track the address/mode, the chip select and the output gate. `valid` is high only when all three have reached their limits (TAA_CYC, TACE_CYC, TOE_CYC) without a restart. While a new address is pending, the data lanes keep the last completed word. When the output gate closes, the lanes keep driving for TOE_CYC more cycles and then float. Each lane has its own drive-enable output in place of a tri-state buffer. Each output enable has a polarity set at build time. The second enable can also be set to be ignored.

Top module: `bwrom_port`

## Requirements
- R1: In word mode (`word_mode`=1), once `valid` is high, `dout` equals the word at `addr` and `dout_en` is 16'hFFFF.
- R2: In byte mode (`word_mode`=0), once `valid` is high, `dout[7:0]` holds bits 7:0 of the addressed word when `lsb_io_in`=0 and bits 15:8 when `lsb_io_in`=1, and `dout[15:8]` is 8'h00.
- R3: Whenever the mode sampled at the last clock edge is byte mode, `dout_en[15:8]` is 8'h00.
- R4: With `chip_sel_n` high, `valid` drops after the next edge. All lanes float from the (TOE_CYC+1)th edge on and stay floating while the chip is deselected, whatever the other inputs do.
- R5: The output gate is open only while the chip is selected, `oe_a_in` equals OE_A_ACTIVE, and `oe_b_in` equals OE_B_MODE (0 = active low, 1 = active high). If the gate closes, `valid` drops after the next edge.
- R6: With OE_B_MODE=2, `oe_b_in` has no effect on any output.
- R7: `valid` rises exactly TAA_CYC edges after the last change of address, mode or byte select. It rises exactly TACE_CYC edges after chip select, and exactly TOE_CYC edges after the gate opens, counting the edge that samples the change. Lanes drive whenever the gate has been open for TOE_CYC edges.
- R8: While an address access is still pending, `dout` keeps its previous value.
- R9: A mode switch, or a change of `lsb_io_in` in byte mode, restarts the address count. A change of `lsb_io_in` in word mode does not.
- R10: After the edge that samples the gate closing, the lanes that were driving keep driving for TOE_CYC more cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_sel_n | input | 1 | Chip select, active low; high means standby |
| oe_a_in | input | 1 | First output enable, polarity from OE_A_ACTIVE |
| oe_b_in | input | 1 | Second output enable, polarity or ignore from OE_B_MODE |
| word_mode | input | 1 | 1 = 16-bit words, 0 = bytes |
| addr | input | ADDR_W | Word address |
| lsb_io_in | input | 1 | Input side of the shared pin; byte select in byte mode |
| dout | output | 16 | Data lanes; bit 15 is the output side of the shared pin |
| dout_en | output | 16 | Per-lane drive enable (0 = high impedance) |
| valid | output | 1 | All access delays met |

## Verification
The bench aims at the exact edge on which `valid` rises after each kind of restart. A design off by one in any counter, or one that does not restart on a mode switch, would raise `valid` early or late. It toggles the byte select in word mode, where a design that keyed on the raw pin would drop `valid` for no reason. It checks the disable tail after both the output enable and the chip select close. A design without the tail, or with a tail of the wrong length, floats the lanes too soon or too late. Upper lanes in byte mode and a second enable set to be ignored are checked at `dout_en`, where a wrong design would drive the upper byte or fall into high impedance.

// File: rtl/bwrom_pkg.sv
`timescale 1ns/1ps
package bwrom_pkg;
  localparam int OEB_LOW    = 0;
  localparam int OEB_HIGH   = 1;
  localparam int OEB_IGNORE = 2;

  // contents of the array: a mixing function of the word index and a seed
  function automatic logic [15:0] rom_word(input logic [31:0] idx, input logic [31:0] seed);
    logic [31:0] t;
    t = idx * 32'd40503 + seed;
    return t[23:8] ^ t[15:0];
  endfunction

  // places a word or one of its halves on the lanes
  function automatic logic [15:0] lane_pick(input logic [15:0] w, input logic word, input logic hi);
    if (word) return w;
    return {8'h00, (hi ? w[15:8] : w[7:0])};
  endfunction
endpackage

// File: rtl/bwrom_age_timer.sv
`timescale 1ns/1ps
module bwrom_age_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic done,
  output logic done_next,
  output logic [$clog2(LIMIT+1)-1:0] age
);
  localparam int W = $clog2(LIMIT+1);
  localparam logic [W-1:0] LIM = W'(LIMIT);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] age_nx;

  always_comb begin
    if (!run)            age_nx = '0;
    else if (restart)    age_nx = ONE;
    else if (age == LIM) age_nx = LIM;
    else                 age_nx = age + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else        age <= age_nx;
  end

  assign done      = (age == LIM);
  assign done_next = (age_nx == LIM);
endmodule

// File: rtl/bwrom_fetch.sv
`timescale 1ns/1ps
module bwrom_fetch import bwrom_pkg::*; #(
  parameter int          ADDR_W = 17,
  parameter logic [31:0] SEED   = 32'h0000_1234
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              word,
  input  logic              hi,
  input  logic [ADDR_W-1:0] addr,
  output logic [15:0]       data_q
);
  logic [15:0] picked;
  assign picked = lane_pick(rom_word(32'(addr), SEED), word, hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (load) data_q <= picked;
  end
endmodule

// File: rtl/bwrom_drive_gate.sv
`timescale 1ns/1ps
module bwrom_drive_gate #(
  parameter int TOE_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        gate,
  input  logic        oe_done,
  input  logic        word_q,
  output logic        drive,
  output logic [15:0] lane_en,
  output logic [$clog2(TOE_CYC+1)-1:0] tail
);
  localparam int TW = $clog2(TOE_CYC+1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            tail <= '0;
    else if (gate)         tail <= '0;
    else if (oe_done)      tail <= TW'(TOE_CYC);
    else if (tail != '0)   tail <= tail - TW'(1);
  end

  assign drive   = oe_done | (tail != '0);
  assign lane_en = drive ? (word_q ? 16'hFFFF : 16'h00FF) : 16'h0000;

  // R10: a gate closing while fully open leaves the lanes driven next cycle
  assert_tail_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_done && !gate) |=> drive);
endmodule

// File: rtl/bwrom_port.sv
`timescale 1ns/1ps
module bwrom_port import bwrom_pkg::*; #(
  parameter int          ADDR_W      = 17,
  parameter int          TAA_CYC     = 4,
  parameter int          TACE_CYC    = 4,
  parameter int          TOE_CYC     = 2,
  parameter bit          OE_A_ACTIVE = 1'b0,
  parameter int          OE_B_MODE   = OEB_HIGH,
  parameter logic [31:0] SEED        = 32'h0000_1234
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel_n,
  input  logic              oe_a_in,
  input  logic              oe_b_in,
  input  logic              word_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lsb_io_in,
  output logic [15:0]       dout,
  output logic [15:0]       dout_en,
  output logic              valid
);
  localparam int KEY_W = ADDR_W + 2;
  localparam int AW    = $clog2(TAA_CYC+1);
  localparam int CW    = $clog2(TACE_CYC+1);
  localparam int OW    = $clog2(TOE_CYC+1);

  // access key: mode, word address, byte select (zero in word mode)
  logic [KEY_W-1:0] key, key_q;
  logic             key_change;
  assign key        = {word_mode, addr, (~word_mode) & lsb_io_in};
  assign key_change = (key != key_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= '0;
    else        key_q <= key;
  end

  logic word_q;
  assign word_q = key_q[KEY_W-1];

  // enable decoding
  logic chip_on, oea_ok, oeb_ok, gate;
  assign chip_on = ~chip_sel_n;
  assign oea_ok  = (oe_a_in == OE_A_ACTIVE);
  generate
    if (OE_B_MODE == OEB_IGNORE) begin : g_oeb_ignore
      assign oeb_ok = 1'b1;
    end else begin : g_oeb_level
      assign oeb_ok = (oe_b_in == OE_B_MODE[0]);
    end
  endgenerate
  assign gate = chip_on & oea_ok & oeb_ok;

  // three access-age counters
  logic          a_done, a_done_nx, c_done, c_done_nx, o_done, o_done_nx;
  logic [AW-1:0] a_age;
  logic [CW-1:0] c_age;
  logic [OW-1:0] o_age;

  bwrom_age_timer #(.LIMIT(TAA_CYC)) u_addr_age (
    .clk(clk), .rst_n(rst_n), .run(1'b1), .restart(key_change),
    .done(a_done), .done_next(a_done_nx), .age(a_age));

  bwrom_age_timer #(.LIMIT(TACE_CYC)) u_chip_age (
    .clk(clk), .rst_n(rst_n), .run(chip_on), .restart(1'b0),
    .done(c_done), .done_next(c_done_nx), .age(c_age));

  bwrom_age_timer #(.LIMIT(TOE_CYC)) u_oe_age (
    .clk(clk), .rst_n(rst_n), .run(gate), .restart(1'b0),
    .done(o_done), .done_next(o_done_nx), .age(o_age));

  // data register loads on the edge where the address access completes
  logic [15:0] data_q;
  bwrom_fetch #(.ADDR_W(ADDR_W), .SEED(SEED)) u_fetch (
    .clk(clk), .rst_n(rst_n), .load(a_done_nx), .word(word_mode),
    .hi(lsb_io_in), .addr(addr), .data_q(data_q));

  // lane drive with disable tail
  logic          drive;
  logic [15:0]   lane_en;
  logic [OW-1:0] tail;
  bwrom_drive_gate #(.TOE_CYC(TOE_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .gate(gate), .oe_done(o_done), .word_q(word_q),
    .drive(drive), .lane_en(lane_en), .tail(tail));

  assign dout    = data_q;
  assign dout_en = lane_en;
  assign valid   = a_done & c_done & o_done;

  // R3: upper lanes never drive in byte mode
  assert_upper_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !word_q |-> (dout_en[15:8] == 8'h00));

  // R4: deselected chip with tail spent leaves all lanes floating
  assert_standby_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_age == '0 && tail == '0) |-> (dout_en == 16'h0000));

  // R5: the output gate only ages while the chip is selected
  assert_gate_needs_chip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (o_age != '0) |-> (c_age != '0));

  // R7: valid data is always on driven lanes
  assert_valid_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (&dout_en[7:0]) && drive);

  // R8: pending address access keeps the previous data
  assert_hold_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !a_done |-> $stable(dout));

  // R9: any change of the access key drops valid on the next cycle
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (TAA_CYC > 1 && key_change) |=> !valid);
endmodule

// File: tb/bwrom_port_tb_top.sv
`timescale 1ns/1ps
module bwrom_ref_model #(
  parameter int          TAA   = 4,
  parameter int          TACE  = 4,
  parameter int          TOE   = 2,
  parameter bit          OEA   = 1'b0,
  parameter int          OEB   = 1,
  parameter logic [31:0] SEED  = 32'h0000_1234
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chip_sel_n,
  input  logic        oe_a_in,
  input  logic        oe_b_in,
  input  logic        word_mode,
  input  logic [16:0] addr,
  input  logic        lsb_io_in,
  output logic [15:0] m_dout,
  output logic [15:0] m_en,
  output logic        m_valid
);
  int  last_addr, last_sel, a_n, c_n, o_n, tail_n;
  bit  last_word, cur_word;
  logic [15:0] held;

  function automatic int unsigned mix(input int unsigned a);
    longint unsigned p;
    p = (longint'(a) * 40503 + longint'(SEED)) % 64'h1_0000_0000;
    return int'(((p >> 8) ^ p) & 64'hFFFF);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr = 0; last_sel = 0; last_word = 0; cur_word = 0;
      a_n = 0; c_n = 0; o_n = 0; tail_n = 0; held = 16'h0;
    end else begin
      bit ce, open, moved;
      int sel;
      ce   = !chip_sel_n;
      open = ce && (oe_a_in == OEA) && (OEB == 2 || oe_b_in == OEB[0]);
      sel  = word_mode ? 0 : int'(lsb_io_in);
      moved = (int'(addr) != last_addr) || (sel != last_sel) || (word_mode != last_word);
      last_addr = int'(addr); last_sel = sel; last_word = word_mode;
      a_n = moved ? 1 : ((a_n < TAA) ? a_n + 1 : TAA);
      if (a_n == TAA) begin
        int unsigned w;
        w = mix(int'(addr));
        if (word_mode) held = w[15:0];
        else held = {8'h00, (sel == 1) ? w[15:8] : w[7:0]};
      end
      c_n = ce ? ((c_n < TACE) ? c_n + 1 : TACE) : 0;
      if (open) tail_n = 0;
      else if (o_n == TOE) tail_n = TOE;
      else if (tail_n > 0) tail_n = tail_n - 1;
      o_n = open ? ((o_n < TOE) ? o_n + 1 : TOE) : 0;
      cur_word = word_mode;
    end
  end

  always_comb begin
    m_valid = (a_n == TAA) && (c_n == TACE) && (o_n == TOE);
    if ((o_n == TOE) || (tail_n > 0)) m_en = cur_word ? 16'hFFFF : 16'h00FF;
    else m_en = 16'h0000;
    m_dout = held;
  end
endmodule

module bwrom_port_tb_top;
  localparam int TAA = 4, TACE = 4, TOE = 2;
  localparam logic [31:0] SEED = 32'h0000_1234;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_sel_n = 1'b1, oe_a_in = 1'b1, oe_b_in = 1'b0, word_mode = 1'b1, lsb_io_in = 1'b0;
  logic [16:0] addr = '0;
  logic [15:0] dout, dout_en, dc_dout, dc_en, m_dout, m_en, md_dout, md_en;
  logic valid, dc_valid, m_valid, md_valid;

  int checks = 0, errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  bwrom_port #(.TAA_CYC(TAA), .TACE_CYC(TACE), .TOE_CYC(TOE), .OE_A_ACTIVE(1'b0),
               .OE_B_MODE(1), .SEED(SEED)) dut_i (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .oe_a_in(oe_a_in), .oe_b_in(oe_b_in),
    .word_mode(word_mode), .addr(addr), .lsb_io_in(lsb_io_in),
    .dout(dout), .dout_en(dout_en), .valid(valid));

  bwrom_port #(.TAA_CYC(TAA), .TACE_CYC(TACE), .TOE_CYC(TOE), .OE_A_ACTIVE(1'b0),
               .OE_B_MODE(2), .SEED(SEED)) dut_dc_i (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .oe_a_in(oe_a_in), .oe_b_in(oe_b_in),
    .word_mode(word_mode), .addr(addr), .lsb_io_in(lsb_io_in),
    .dout(dc_dout), .dout_en(dc_en), .valid(dc_valid));

  bwrom_ref_model #(.TAA(TAA), .TACE(TACE), .TOE(TOE), .OEA(1'b0), .OEB(1), .SEED(SEED)) ref_i (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .oe_a_in(oe_a_in), .oe_b_in(oe_b_in),
    .word_mode(word_mode), .addr(addr), .lsb_io_in(lsb_io_in),
    .m_dout(m_dout), .m_en(m_en), .m_valid(m_valid));

  bwrom_ref_model #(.TAA(TAA), .TACE(TACE), .TOE(TOE), .OEA(1'b0), .OEB(2), .SEED(SEED)) ref_dc_i (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .oe_a_in(oe_a_in), .oe_b_in(oe_b_in),
    .word_mode(word_mode), .addr(addr), .lsb_io_in(lsb_io_in),
    .m_dout(md_dout), .m_en(md_en), .m_valid(md_valid));

  function automatic logic [15:0] exp_word(input int unsigned a);
    longint unsigned p;
    p = (longint'(a) * 40503 + longint'(SEED)) % 64'h1_0000_0000;
    return 16'(((p >> 8) ^ p) & 64'hFFFF);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // cycle-by-cycle comparison against the reference models
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(valid == m_valid, cur_req, "valid", 16'(valid), 16'(m_valid));
      chk(dout_en == m_en, cur_req, "dout_en", dout_en, m_en);
      chk(dout == m_dout, cur_req, "dout", dout, m_dout);
      chk(dc_valid == md_valid, "R6", "dc valid", 16'(dc_valid), 16'(md_valid));
      chk(dc_en == md_en, "R6", "dc dout_en", dc_en, md_en);
      chk(dc_dout == md_dout, "R6", "dc dout", dc_dout, md_dout);
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [16:0] a1, a2, a3, a4;
    logic [15:0] w;
    int unsigned rs;
    a1 = 17'h0_0005; a2 = 17'h1_FFFF; a3 = 17'h0_8421; a4 = 17'h1_0000;

    // reset state (R4)
    step(3);
    chk(dout_en == 16'h0 && valid == 1'b0, "R4", "reset float", dout_en, 16'h0);
    chk(dout == 16'h0, "R4", "reset data", dout, 16'h0);
    rst_n = 1'b1;
    step(2);

    // R1 / R7: word read, valid exactly after TAA edges
    cur_req = "R1";
    chip_sel_n = 1'b0; oe_a_in = 1'b0; oe_b_in = 1'b1; word_mode = 1'b1; addr = a1;
    step(TAA - 1);
    chk(valid == 1'b0, "R7", "valid early", 16'(valid), 16'h0);
    step(1);
    chk(valid == 1'b1, "R7", "valid on time", 16'(valid), 16'h1);
    chk(dout == exp_word(a1), "R1", "word data", dout, exp_word(a1));
    chk(dout_en == 16'hFFFF, "R1", "word lanes", dout_en, 16'hFFFF);

    // R8: hold previous data during a pending access
    cur_req = "R8";
    addr = a2;
    step(1);
    chk(valid == 1'b0 && dout == exp_word(a1), "R8", "held data", dout, exp_word(a1));
    step(TAA - 1);
    chk(valid == 1'b1 && dout == exp_word(a2), "R1", "second word", dout, exp_word(a2));

    // R9: byte-select pin ignored in word mode
    cur_req = "R9";
    lsb_io_in = 1'b1;
    step(1);
    chk(valid == 1'b1, "R9", "word-mode pin toggle", 16'(valid), 16'h1);

    // R2 / R3 / R9: byte mode
    cur_req = "R2";
    word_mode = 1'b0; lsb_io_in = 1'b0; addr = a3;
    step(1);
    chk(valid == 1'b0, "R9", "mode switch restart", 16'(valid), 16'h0);
    chk(dout_en == 16'h00FF, "R3", "byte lanes", dout_en, 16'h00FF);
    step(TAA - 1);
    w = exp_word(a3);
    chk(valid == 1'b1 && dout == {8'h00, w[7:0]}, "R2", "low byte", dout, {8'h00, w[7:0]});
    lsb_io_in = 1'b1;
    step(1);
    chk(valid == 1'b0, "R9", "byte select restart", 16'(valid), 16'h0);
    step(TAA - 1);
    chk(valid == 1'b1 && dout == {8'h00, w[15:8]}, "R2", "high byte", dout, {8'h00, w[15:8]});
    chk(dout_en[15:8] == 8'h00, "R3", "upper float", dout_en, 16'h00FF);

    // R5 / R10: first enable closes, tail then float
    cur_req = "R10";
    oe_a_in = 1'b1;
    step(1);
    chk(valid == 1'b0 && dout_en == 16'h00FF, "R10", "tail cycle 1", dout_en, 16'h00FF);
    step(TOE - 1);
    chk(dout_en == 16'h00FF, "R10", "tail last", dout_en, 16'h00FF);
    step(1);
    chk(dout_en == 16'h0000, "R5", "oe_a float", dout_en, 16'h0000);
    oe_a_in = 1'b0;
    step(TOE - 1);
    chk(dout_en == 16'h0000, "R7", "oe latency early", dout_en, 16'h0000);
    step(1);
    chk(valid == 1'b1 && dout_en == 16'h00FF, "R7", "oe latency met", dout_en, 16'h00FF);

    // R5 / R6: second enable inactive
    cur_req = "R5";
    oe_b_in = 1'b0;
    step(TOE + 1);
    chk(valid == 1'b0 && dout_en == 16'h0000, "R5", "oe_b float", dout_en, 16'h0000);
    chk(dc_valid == 1'b1 && dc_en == 16'h00FF, "R6", "oe_b ignored", dc_en, 16'h00FF);
    oe_b_in = 1'b1;
    step(TOE);

    // R4: standby
    cur_req = "R4";
    chip_sel_n = 1'b1;
    step(1);
    chk(valid == 1'b0 && dout_en == 16'h00FF, "R4", "deselect tail", dout_en, 16'h00FF);
    step(TOE);
    chk(dout_en == 16'h0000 && dc_en == 16'h0000, "R4", "standby float", dout_en, 16'h0000);
    addr = a4; word_mode = 1'b1; oe_a_in = 1'b1;
    step(2);
    oe_a_in = 1'b0;
    step(4);
    chk(dout_en == 16'h0000 && valid == 1'b0, "R4", "standby ignores inputs", dout_en, 16'h0000);

    // R7: chip select latency
    cur_req = "R7";
    chip_sel_n = 1'b0;
    step(TACE - 1);
    chk(valid == 1'b0, "R7", "chip latency early", 16'(valid), 16'h0);
    step(1);
    chk(valid == 1'b1 && dout == exp_word(a4) && dout_en == 16'hFFFF, "R7", "chip latency met",
        dout, exp_word(a4));

    // mixed traffic against the reference models
    cur_req = "R1";
    rs = 32'h2468_ACE1;
    for (int i = 0; i < 4000; i++) begin
      rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
      if (rs[3:0] < 3)  addr = {rs[20], 12'h0, rs[19:16]};
      if (rs[7:4] == 0) word_mode = ~word_mode;
      if (rs[11:8] < 4) lsb_io_in = ~lsb_io_in;
      if (rs[15:12] == 1) oe_a_in = ~oe_a_in;
      if (rs[15:12] == 2) oe_b_in = ~oe_b_in;
      if (rs[27:24] == 3) chip_sel_n = ~chip_sel_n;
      if (chip_sel_n && rs[31:29] == 0) chip_sel_n = 1'b0;
      if (oe_a_in && rs[31:29] == 1) oe_a_in = 1'b0;
      if (!oe_b_in && rs[31:29] == 2) oe_b_in = 1'b1;
      cur_req = word_mode ? "R1" : "R2";
      step(1);
    end
    step(2);
    finish_run();
  end
endmodule